// File: doc/BRIEF.md
# Cache Request Hazard Checker

This block decides, in the same cycle, whether a request about to enter one of two cache request pipelines must be sent back to its queue because it would collide with work already in flight. It compares the candidate against three groups: the pending queue of the candidate's own pipe, the request sitting in the final stage of the opposite pipe, and the miss wait registers and the two shared overflow registers. Any collision raises a single `interfere_o` flag, which the surrounding engine uses to requeue the candidate.

All comparisons work on cache-line addresses, so the byte offset inside a line plays no part. Priority numbers follow the rule "smaller is more urgent". A candidate only yields to a queued, waiting or overflow entry that is strictly more urgent than itself. The request in the opposite pipe's last stage blocks on an address match alone. A request that invalidates the whole cache matches every address. Ordinary requests also step aside whenever a replay request is still moving through either pipeline. A preload that covers several lines is checked on each of them.

The queues, stages and wait registers live elsewhere; they arrive here as flat vectors, with one slice per entry. The checker holds no state.

Top module: `cache_hazard_check`

## Requirements
- R1: Address comparisons use only bits `[ADDR_W-1:OFF_W]`, where `OFF_W = log2(LINE_BYTES)`. Two addresses in the same line match whatever their low offset bits are.
- R2: The candidate is a wildcard, matching every entry's address, when its kind is 5 (invalidate all) or when the line being checked is all ones. Kind codes are 0 load, 1 store, 2 preload, 3 unlock, 4 invalidate line, 5 invalidate all, 6 replay.
- R3: A valid entry in the candidate's own pipe queue interferes when its line matches and its priority is strictly lower numerically than the candidate's. The other pipe's queue is never consulted.
- R4: The valid request in the final stage (index `STAGES-1`) of the other pipe (pipe index XOR 1) interferes on a line match at any priority. Earlier stages and the candidate's own final stage do not interfere by address.
- R5: A valid wait register of either pipe interferes when its line matches and its priority is strictly more urgent than the candidate's.
- R6: If the candidate's kind is not 6 (replay), a valid stage of either pipe holding kind 6 forces interference. A replay candidate ignores this rule.
- R7: Either overflow register (index 0 primary, 1 secondary) interferes when valid, line-matching and strictly more urgent than the candidate.
- R8: For kind 2 (preload) the number of lines checked is `cand_lines_i`, with 0 treated as 1 and values above `MAX_LINES` clamped to `MAX_LINES`. Line k is the candidate line plus k, and a hit on any of these lines interferes. Every other kind checks exactly one line.
- R9: With no condition from R3 to R7 present, `interfere_o` is 0. The output follows the inputs combinationally and has no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cand_addr_i | input | ADDR_W | Candidate byte address |
| cand_prio_i | input | PRIO_W | Candidate priority (lower is more urgent) |
| cand_kind_i | input | 3 | Candidate kind code |
| cand_pipe_i | input | 1 | Pipe the candidate belongs to |
| cand_lines_i | input | clog2(MAX_LINES+1) | Preload line count |
| q_vld_i | input | 2*QDEPTH | Queue entry valid, pipe p entry i at p*QDEPTH+i |
| q_addr_i | input | 2*QDEPTH*ADDR_W | Queue entry addresses |
| q_prio_i | input | 2*QDEPTH*PRIO_W | Queue entry priorities |
| st_vld_i | input | 2*STAGES | Stage valid, pipe p stage s at p*STAGES+s |
| st_addr_i | input | 2*STAGES*ADDR_W | Stage addresses |
| st_kind_i | input | 2*STAGES*3 | Stage kind codes |
| w_vld_i | input | 2*NWAIT | Wait register valid, pipe p slot j at p*NWAIT+j |
| w_addr_i | input | 2*NWAIT*ADDR_W | Wait register addresses |
| w_prio_i | input | 2*NWAIT*PRIO_W | Wait register priorities |
| ov_vld_i | input | 2 | Overflow register valid (0 primary, 1 secondary) |
| ov_addr_i | input | 2*ADDR_W | Overflow register addresses |
| ov_prio_i | input | 2*PRIO_W | Overflow register priorities |
| interfere_o | output | 1 | Candidate must be requeued |

## Verification
The immediate checks assume that inputs are settled values with no X, and that priority and kind fields carry defined codes. They do not assume that queue contents are sorted or that entries are unique. The stimulus respects this by driving every field, including the slices of invalid entries, from a small address pool. The pool is built to produce frequent line matches, wildcard lines and every kind code, and each vector is compared against an arithmetic model of R1 to R9.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [2:0] {
    REQ_LOAD      = 3'd0,
    REQ_STORE     = 3'd1,
    REQ_PRELOAD   = 3'd2,
    REQ_UNLOCK    = 3'd3,
    REQ_INVAL     = 3'd4,
    REQ_INVAL_ALL = 3'd5,
    REQ_REPLAY    = 3'd6
  } req_kind_e;
  localparam int KIND_W = 3;
endpackage

// File: rtl/hzd_line_match.sv
module hzd_line_match #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int PRIO_W = 8,
  parameter int QDEPTH = 4,
  parameter int NWAIT  = 2
) (
  input  logic [ADDR_W-1:OFF_W]         line_i,
  input  logic                          wild_i,
  input  logic [PRIO_W-1:0]             prio_i,
  input  logic [QDEPTH-1:0]             q_vld_i,
  input  logic [QDEPTH*ADDR_W-1:0]      q_addr_i,
  input  logic [QDEPTH*PRIO_W-1:0]      q_prio_i,
  input  logic                          tail_vld_i,
  input  logic [ADDR_W-1:0]             tail_addr_i,
  input  logic [2*NWAIT-1:0]            w_vld_i,
  input  logic [2*NWAIT*ADDR_W-1:0]     w_addr_i,
  input  logic [2*NWAIT*PRIO_W-1:0]     w_prio_i,
  input  logic [1:0]                    ov_vld_i,
  input  logic [2*ADDR_W-1:0]           ov_addr_i,
  input  logic [2*PRIO_W-1:0]           ov_prio_i,
  output logic                          hit_o
);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic q_hit, t_hit, w_hit, o_hit;

  function automatic logic same_line(input logic [ADDR_W-1:0] a,
                                     input logic [LINE_W-1:0] ln,
                                     input logic wild);
    return wild || (a[ADDR_W-1:OFF_W] == ln);
  endfunction

  always_comb begin
    q_hit = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (q_vld_i[i] && same_line(q_addr_i[i*ADDR_W +: ADDR_W], line_i, wild_i)
          && (q_prio_i[i*PRIO_W +: PRIO_W] < prio_i))
        q_hit = 1'b1;
    end
    t_hit = tail_vld_i && same_line(tail_addr_i, line_i, wild_i);
    w_hit = 1'b0;
    for (int j = 0; j < 2*NWAIT; j++) begin
      if (w_vld_i[j] && same_line(w_addr_i[j*ADDR_W +: ADDR_W], line_i, wild_i)
          && (w_prio_i[j*PRIO_W +: PRIO_W] < prio_i))
        w_hit = 1'b1;
    end
    o_hit = 1'b0;
    for (int m = 0; m < 2; m++) begin
      if (ov_vld_i[m] && same_line(ov_addr_i[m*ADDR_W +: ADDR_W], line_i, wild_i)
          && (ov_prio_i[m*PRIO_W +: PRIO_W] < prio_i))
        o_hit = 1'b1;
    end
    hit_o = q_hit | t_hit | w_hit | o_hit;

    if (wild_i && tail_vld_i)
      AST_WILD_TAIL: assert (hit_o) else $error("wildcard missed tail"); // R2
    if (tail_vld_i && (tail_addr_i[ADDR_W-1:OFF_W] == line_i))
      AST_TAIL_ANY_PRIO: assert (hit_o) else $error("tail match missed"); // R4
    if (prio_i == '0)
      AST_TOP_PRIO_QUEUE: assert (!q_hit) else $error("queue beat prio 0"); // R3
    if (prio_i == '0)
      AST_TOP_PRIO_WAIT: assert (!w_hit) else $error("wait beat prio 0"); // R5
    if (prio_i == '0)
      AST_TOP_PRIO_OVF: assert (!o_hit) else $error("ovf beat prio 0"); // R7
    AST_HIT_NEEDS_SOURCE: assert (!hit_o || (|q_vld_i) || tail_vld_i
                                  || (|w_vld_i) || (|ov_vld_i))
      else $error("hit with no valid source"); // R9
  end
endmodule

// File: rtl/hzd_replay_scan.sv
module hzd_replay_scan
  import hzd_pkg::*;
#(
  parameter int NSLOT = 6
) (
  input  logic [NSLOT-1:0]        vld_i,
  input  logic [NSLOT*KIND_W-1:0] kind_i,
  output logic                    found_o
);
  always_comb begin
    found_o = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (vld_i[s] && (kind_i[s*KIND_W +: KIND_W] == REQ_REPLAY))
        found_o = 1'b1;
    end
  end
endmodule

// File: rtl/cache_hazard_check.sv
module cache_hazard_check
  import hzd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PRIO_W     = 8,
  parameter int QDEPTH     = 4,
  parameter int STAGES     = 3,
  parameter int NWAIT      = 2,
  parameter int MAX_LINES  = 4
) (
  input  logic [ADDR_W-1:0]                  cand_addr_i,
  input  logic [PRIO_W-1:0]                  cand_prio_i,
  input  logic [2:0]                         cand_kind_i,
  input  logic                               cand_pipe_i,
  input  logic [$clog2(MAX_LINES+1)-1:0]     cand_lines_i,
  input  logic [2*QDEPTH-1:0]                q_vld_i,
  input  logic [2*QDEPTH*ADDR_W-1:0]         q_addr_i,
  input  logic [2*QDEPTH*PRIO_W-1:0]         q_prio_i,
  input  logic [2*STAGES-1:0]                st_vld_i,
  input  logic [2*STAGES*ADDR_W-1:0]         st_addr_i,
  input  logic [2*STAGES*3-1:0]              st_kind_i,
  input  logic [2*NWAIT-1:0]                 w_vld_i,
  input  logic [2*NWAIT*ADDR_W-1:0]          w_addr_i,
  input  logic [2*NWAIT*PRIO_W-1:0]          w_prio_i,
  input  logic [1:0]                         ov_vld_i,
  input  logic [2*ADDR_W-1:0]                ov_addr_i,
  input  logic [2*PRIO_W-1:0]                ov_prio_i,
  output logic                               interfere_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(MAX_LINES+1);

  logic [LINE_W-1:0]        cand_line;
  logic                     inval_all;
  logic [CNT_W-1:0]         lines_used;
  logic [QDEPTH-1:0]        own_vld;
  logic [QDEPTH*ADDR_W-1:0] own_addr;
  logic [QDEPTH*PRIO_W-1:0] own_prio;
  logic                     tail_vld;
  logic [ADDR_W-1:0]        tail_addr;
  logic [MAX_LINES-1:0]     line_hit;
  logic [MAX_LINES-1:0]     line_en;
  logic                     replay_any;

  assign cand_line = cand_addr_i[ADDR_W-1:OFF_W];
  assign inval_all = (cand_kind_i == REQ_INVAL_ALL);

  // Line count for a multi-line preload; every other kind checks one line.
  always_comb begin
    lines_used = CNT_W'(1);
    if (cand_kind_i == REQ_PRELOAD) begin
      if (cand_lines_i == '0)
        lines_used = CNT_W'(1);
      else if (cand_lines_i > CNT_W'(MAX_LINES))
        lines_used = CNT_W'(MAX_LINES);
      else
        lines_used = cand_lines_i;
    end
  end

  // Own queue and opposite pipe's final stage.
  always_comb begin
    if (cand_pipe_i) begin
      own_vld   = q_vld_i[2*QDEPTH-1:QDEPTH];
      own_addr  = q_addr_i[2*QDEPTH*ADDR_W-1:QDEPTH*ADDR_W];
      own_prio  = q_prio_i[2*QDEPTH*PRIO_W-1:QDEPTH*PRIO_W];
      tail_vld  = st_vld_i[STAGES-1];
      tail_addr = st_addr_i[(STAGES-1)*ADDR_W +: ADDR_W];
    end else begin
      own_vld   = q_vld_i[QDEPTH-1:0];
      own_addr  = q_addr_i[QDEPTH*ADDR_W-1:0];
      own_prio  = q_prio_i[QDEPTH*PRIO_W-1:0];
      tail_vld  = st_vld_i[2*STAGES-1];
      tail_addr = st_addr_i[(2*STAGES-1)*ADDR_W +: ADDR_W];
    end
  end

  for (genvar k = 0; k < MAX_LINES; k++) begin : g_line
    logic [LINE_W-1:0] ln;
    logic              wl;
    assign ln         = cand_line + LINE_W'(k);
    assign wl         = inval_all || (&ln);
    assign line_en[k] = (CNT_W'(k) < lines_used);

    hzd_line_match #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .PRIO_W (PRIO_W),
      .QDEPTH (QDEPTH),
      .NWAIT  (NWAIT)
    ) u_match (
      .line_i      (ln),
      .wild_i      (wl),
      .prio_i      (cand_prio_i),
      .q_vld_i     (own_vld),
      .q_addr_i    (own_addr),
      .q_prio_i    (own_prio),
      .tail_vld_i  (tail_vld),
      .tail_addr_i (tail_addr),
      .w_vld_i     (w_vld_i),
      .w_addr_i    (w_addr_i),
      .w_prio_i    (w_prio_i),
      .ov_vld_i    (ov_vld_i),
      .ov_addr_i   (ov_addr_i),
      .ov_prio_i   (ov_prio_i),
      .hit_o       (line_hit[k])
    );
  end

  hzd_replay_scan #(
    .NSLOT (2*STAGES)
  ) u_replay (
    .vld_i   (st_vld_i),
    .kind_i  (st_kind_i),
    .found_o (replay_any)
  );

  always_comb begin
    interfere_o = (|(line_hit & line_en))
                  || ((cand_kind_i != REQ_REPLAY) && replay_any);

    if ((cand_kind_i != REQ_REPLAY) && replay_any)
      AST_REPLAY_YIELD: assert (interfere_o) else $error("replay not yielded"); // R6
    if (cand_kind_i != REQ_PRELOAD)
      AST_SINGLE_LINE: assert (line_en == MAX_LINES'(1)) else $error("span on non-preload"); // R8
    if ((cand_kind_i == REQ_REPLAY) && !(|(line_hit & line_en)))
      AST_REPLAY_CAND_FREE: assert (!interfere_o) else $error("replay candidate blocked"); // R6
  end
endmodule

// File: tb/sim_cache_hazard_check.sv
module sim_cache_hazard_check;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LB = 4;
  localparam int PW = 2;
  localparam int QD = 2;
  localparam int ST = 2;
  localparam int NW = 1;
  localparam int ML = 2;
  localparam int CW = 2;

  logic clk;
  logic rst_n;
  int   n_tests;
  int   n_fail;
  bit   done;

  logic [AW-1:0]      c_addr;
  logic [PW-1:0]      c_prio;
  logic [2:0]         c_kind;
  logic               c_pipe;
  logic [CW-1:0]      c_lines;
  logic [2*QD-1:0]    q_vld;
  logic [2*QD*AW-1:0] q_addr;
  logic [2*QD*PW-1:0] q_prio;
  logic [2*ST-1:0]    s_vld;
  logic [2*ST*AW-1:0] s_addr;
  logic [2*ST*3-1:0]  s_kind;
  logic [2*NW-1:0]    w_vld;
  logic [2*NW*AW-1:0] w_addr;
  logic [2*NW*PW-1:0] w_prio;
  logic [1:0]         o_vld;
  logic [2*AW-1:0]    o_addr;
  logic [2*PW-1:0]    o_prio;
  logic               interfere;

  cache_hazard_check #(
    .ADDR_W(AW), .LINE_BYTES(LB), .PRIO_W(PW), .QDEPTH(QD),
    .STAGES(ST), .NWAIT(NW), .MAX_LINES(ML)
  ) u0 (
    .cand_addr_i(c_addr), .cand_prio_i(c_prio), .cand_kind_i(c_kind),
    .cand_pipe_i(c_pipe), .cand_lines_i(c_lines),
    .q_vld_i(q_vld), .q_addr_i(q_addr), .q_prio_i(q_prio),
    .st_vld_i(s_vld), .st_addr_i(s_addr), .st_kind_i(s_kind),
    .w_vld_i(w_vld), .w_addr_i(w_addr), .w_prio_i(w_prio),
    .ov_vld_i(o_vld), .ov_addr_i(o_addr), .ov_prio_i(o_prio),
    .interfere_o(interfere)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic model();
    logic       r;
    logic [5:0] ln;
    logic       wild;
    int         nl;
    int         op;
    r  = 1'b0;
    nl = 1;
    if (c_kind == 3'd2)
      nl = (c_lines == 0) ? 1 : ((int'(c_lines) > ML) ? ML : int'(c_lines));
    op = c_pipe ? 0 : 1;
    for (int k = 0; k < nl; k++) begin
      ln   = c_addr[7:2] + 6'(k);
      wild = (c_kind == 3'd5) || (ln == 6'h3f);
      for (int i = 0; i < QD; i++) begin
        int ix;
        ix = int'(c_pipe) * QD + i;
        if (q_vld[ix] && (wild || q_addr[ix*AW+2 +: 6] == ln) && q_prio[ix*PW +: PW] < c_prio)
          r = 1'b1;
      end
      if (s_vld[op*ST+ST-1] && (wild || s_addr[(op*ST+ST-1)*AW+2 +: 6] == ln))
        r = 1'b1;
      for (int j = 0; j < 2*NW; j++)
        if (w_vld[j] && (wild || w_addr[j*AW+2 +: 6] == ln) && w_prio[j*PW +: PW] < c_prio)
          r = 1'b1;
      for (int m = 0; m < 2; m++)
        if (o_vld[m] && (wild || o_addr[m*AW+2 +: 6] == ln) && o_prio[m*PW +: PW] < c_prio)
          r = 1'b1;
    end
    if (c_kind != 3'd6)
      for (int s = 0; s < 2*ST; s++)
        if (s_vld[s] && s_kind[s*3 +: 3] == 3'd6) r = 1'b1;
    return r;
  endfunction

  task automatic clear_all();
    c_addr = '0; c_prio = '0; c_kind = '0; c_pipe = 1'b0; c_lines = '0;
    q_vld = '0; q_addr = '0; q_prio = '0;
    s_vld = '0; s_addr = '0; s_kind = '0;
    w_vld = '0; w_addr = '0; w_prio = '0;
    o_vld = '0; o_addr = '0; o_prio = '0;
  endtask

  task automatic check(input string req, input logic exp);
    #1;
    n_tests++;
    if (interfere !== exp) begin
      n_fail++;
      $display("FAIL %s: interfere=%b expected=%b", req, interfere, exp);
    end
  endtask

  function automatic logic [7:0] pick_addr();
    logic [5:0] ln;
    case ($urandom % 5)
      0: ln = 6'd4;
      1: ln = 6'd5;
      2: ln = 6'd6;
      3: ln = 6'h3f;
      default: ln = 6'($urandom);
    endcase
    return {ln, 2'($urandom)};
  endfunction

  task automatic randomize_inputs();
    c_addr = pick_addr(); c_prio = 2'($urandom); c_kind = 3'($urandom % 7);
    c_pipe = 1'($urandom); c_lines = 2'($urandom);
    for (int i = 0; i < 2*QD; i++) begin
      q_vld[i] = ($urandom % 3) == 0; q_addr[i*AW +: AW] = pick_addr();
      q_prio[i*PW +: PW] = 2'($urandom);
    end
    for (int s = 0; s < 2*ST; s++) begin
      s_vld[s] = ($urandom % 3) == 0; s_addr[s*AW +: AW] = pick_addr();
      s_kind[s*3 +: 3] = (($urandom % 6) == 0) ? 3'd6 : 3'($urandom % 6);
    end
    for (int j = 0; j < 2*NW; j++) begin
      w_vld[j] = ($urandom % 3) == 0; w_addr[j*AW +: AW] = pick_addr();
      w_prio[j*PW +: PW] = 2'($urandom);
    end
    for (int m = 0; m < 2; m++) begin
      o_vld[m] = ($urandom % 3) == 0; o_addr[m*AW +: AW] = pick_addr();
      o_prio[m*PW +: PW] = 2'($urandom);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    clear_all();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", 1'b0);

    // R3 own queue, strictly more urgent; R1 offset ignored
    @(negedge clk); clear_all();
    q_vld[0] = 1'b1; q_addr[0 +: AW] = {6'd5, 2'd0}; q_prio[0 +: PW] = 2'd1;
    c_addr = {6'd5, 2'd3}; c_prio = 2'd2;
    check("R3 R1 queue urgent", 1'b1);
    c_prio = 2'd1; check("R3 equal prio", 1'b0);
    c_prio = 2'd2; c_pipe = 1'b1; check("R3 other queue", 1'b0);
    c_pipe = 1'b0; c_addr = {6'd6, 2'd0}; check("R1 other line", 1'b0);

    // R4 opposite final stage
    @(negedge clk); clear_all();
    c_addr = {6'd5, 2'd1}; c_prio = 2'd0;
    s_vld[ST+ST-1] = 1'b1; s_addr[(ST+ST-1)*AW +: AW] = {6'd5, 2'd2};
    check("R4 other tail", 1'b1);
    s_vld = '0; s_vld[ST] = 1'b1; s_addr[ST*AW +: AW] = {6'd5, 2'd2};
    check("R4 earlier stage", 1'b0);
    s_vld = '0; s_vld[ST-1] = 1'b1; s_addr[(ST-1)*AW +: AW] = {6'd5, 2'd0};
    check("R4 own tail", 1'b0);

    // R5 wait registers of the other pipe
    @(negedge clk); clear_all();
    c_addr = {6'd9, 2'd0}; c_prio = 2'd3; c_pipe = 1'b0;
    w_vld[1] = 1'b1; w_addr[AW +: AW] = {6'd9, 2'd3}; w_prio[PW +: PW] = 2'd0;
    check("R5 wait urgent", 1'b1);
    w_prio[PW +: PW] = 2'd3; check("R5 wait equal", 1'b0);

    // R7 overflow
    @(negedge clk); clear_all();
    c_addr = {6'd9, 2'd0}; c_prio = 2'd2;
    o_vld[1] = 1'b1; o_addr[AW +: AW] = {6'd9, 2'd1}; o_prio[PW +: PW] = 2'd1;
    check("R7 secondary", 1'b1);
    o_vld[1] = 1'b0; check("R7 invalid", 1'b0);

    // R2 wildcard
    @(negedge clk); clear_all();
    q_vld[0] = 1'b1; q_addr[0 +: AW] = {6'd5, 2'd0}; q_prio[0 +: PW] = 2'd0;
    c_addr = {6'd9, 2'd0}; c_prio = 2'd1; c_kind = 3'd5;
    check("R2 invalidate all", 1'b1);
    c_kind = 3'd4; check("R2 single invalidate", 1'b0);
    c_addr = {6'h3f, 2'd0}; check("R2 all-ones line", 1'b1);

    // R6 replay yield
    @(negedge clk); clear_all();
    s_vld[0] = 1'b1; s_kind[0 +: 3] = 3'd6; s_addr[0 +: AW] = {6'd20, 2'd0};
    c_addr = {6'd9, 2'd0}; c_kind = 3'd0;
    check("R6 load yields", 1'b1);
    c_kind = 3'd6; check("R6 replay candidate", 1'b0);
    c_kind = 3'd0; s_vld[0] = 1'b0; check("R6 invalid replay", 1'b0);

    // R8 preload span
    @(negedge clk); clear_all();
    q_vld[0] = 1'b1; q_addr[0 +: AW] = {6'd5, 2'd0}; q_prio[0 +: PW] = 2'd0;
    c_addr = {6'd4, 2'd2}; c_prio = 2'd1; c_kind = 3'd2; c_lines = 2'd2;
    check("R8 second line", 1'b1);
    c_lines = 2'd3; check("R8 clamp", 1'b1);
    c_lines = 2'd1; check("R8 one line", 1'b0);
    c_lines = 2'd0; check("R8 zero as one", 1'b0);
    c_kind = 3'd0; c_lines = 2'd2; check("R8 load single line", 1'b0);

    // sweep against model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      randomize_inputs();
      check("R1-model sweep", model());
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule